// File: doc/BRIEF.md
# Interrupt Presentation Controller

This block sits beside one processor and decides which single interrupt is shown to it at any time. A source unit offers interrupts as a source number with a priority. The block holds one of them as pending and drives a level interrupt line while it does. The processor works it through a small set of register operations. It can set the current priority below which it accepts work. It can accept the pending interrupt, which returns a 32-bit word and masks at the accepted level. It can signal end of service, and it can read the state without changing it. A write to a software priority register lets the processor raise an inter-processor interrupt on itself. That interrupt then competes with the offered interrupts like any other source.

A lower number means more favoured. An interrupt that loses its place goes back to the source unit as a one-cycle reject pulse carrying its number. This happens when a more favoured arrival displaces it, or when the processor raises its priority over it. Whenever the block becomes idle at an equal or looser priority, it pulses a resend request so that refused sources can offer again. All outputs are registered and change on the clock edge that takes the operation or offer.

Top module: `intr_present_unit`

## Requirements
- R1: After reset the 32-bit presentation word (current priority in bits 31:24, pending source in bits 23:0) is 0, the pending priority is 0xFF, the software interrupt priority is 0xFF and the interrupt line is low.
- R2: With op_code 0, an offer is refused with a reject pulse carrying its own source number if its priority is not below the current priority, or if a source is pending with a pending priority at or below the offered priority; the state is then unchanged.
- R3: An offer that is not refused replaces the pending source and pending priority and raises the line; a source it displaces gets a reject pulse, except source 2, which is reserved for the software interrupt and never appears on the reject output.
- R4: op_code 3 (accept) returns the presentation word as it was before the operation together with the software priority, and lowers the line. It then moves the pending priority into the current priority, clears the source field and sets the pending priority to 0xFF.
- R5: op_code 1 with op_data[7:0] below the current priority stores it; if a source is pending and the new value is at or below its pending priority, the source is dropped (field cleared, pending priority 0xFF, line low) and rejected unless it is source 2.
- R6: op_code 1 with a value at or above the current priority stores it; if nothing is pending, a software-interrupt check runs against the new priority and a resend request pulses.
- R7: op_code 2 stores op_data[7:0] as the software priority. If that value is below the current priority and no pending source holds a pending priority at or below it, source 2 is presented at that priority and the line rises. Any other pending source is rejected at that point.
- R8: op_code 4 (end of service) loads op_data[31:24] into the current priority, pulses the EOI output with op_data[23:0], and if nothing is pending runs the software-interrupt check and pulses a resend request.
- R9: op_code 5 (poll) returns the presentation word and software priority and changes no state.
- R10: An offer in a cycle whose op_code is nonzero, or with source number 0 or 2, is ignored: no reject, no state change.
- R11: The interrupt line is high exactly when the source field is nonzero; every output reflects an input one clock edge after it is sampled, and op_codes 6 and 7 do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| offer_vld | input | 1 | Offer from the source unit this cycle |
| offer_src | input | 24 | Offered source number |
| offer_prio | input | 8 | Offered priority |
| op_code | input | 3 | Register operation: 0 none, 1 set priority, 2 set software priority, 3 accept, 4 end of service, 5 poll |
| op_data | input | 32 | Operation argument |
| irq_out | output | 1 | Level interrupt line to the processor |
| rsp_vld | output | 1 | Response valid for accept or poll |
| rsp_word | output | 32 | Returned presentation word |
| rsp_ipi | output | 8 | Returned software priority |
| rej_vld | output | 1 | Reject pulse to the source unit |
| rej_src | output | 24 | Rejected source number |
| resend_req | output | 1 | Resend request pulse to the source unit |
| eoi_vld | output | 1 | End-of-service pulse to the source unit |
| eoi_src | output | 24 | Source number of the end of service |

## Verification
The hardest state to reach is a pending source being pushed out by the software interrupt, or by a tighter priority. That needs an offer accepted under a loose current priority, then a software priority write or priority write that beats it, with the pending source not itself the software interrupt. Directed steps build exactly that chain, including the drop of a pending software interrupt that must not be rejected. Random stimulus then draws priorities from a narrow range of about a dozen values. Ties and near ties between offered, pending, current and software priorities therefore occur often, while offers landing on operation cycles and reserved source numbers exercise the ignore rules.

// File: rtl/ipu_pkg.sv
package ipu_pkg;
  typedef enum logic [2:0] {
    OP_NONE     = 3'd0,
    OP_SET_CUR  = 3'd1,
    OP_SET_SW   = 3'd2,
    OP_ACCEPT   = 3'd3,
    OP_DONE     = 3'd4,
    OP_PEEK     = 3'd5
  } ipu_op_e;
endpackage

// File: rtl/ipu_prio_gate.sv
// Decides whether a candidate priority may take the presentation slot:
// it must beat the ceiling and must not lose to a pending entry.
module ipu_prio_gate #(
  parameter int PRIO_W = 8
) (
  input  logic [PRIO_W-1:0] cand_prio,
  input  logic [PRIO_W-1:0] ceiling,
  input  logic              busy,
  input  logic [PRIO_W-1:0] held_prio,
  output logic              win
);
  logic beats_ceiling;
  logic held_keeps;
  always_comb begin
    beats_ceiling = cand_prio < ceiling;
    held_keeps    = busy && (held_prio <= cand_prio);
    win           = beats_ceiling && !held_keeps;
  end
endmodule

// File: rtl/intr_present_unit.sv
module intr_present_unit
  import ipu_pkg::*;
#(
  parameter int PRIO_W  = 8,
  parameter int SRC_W   = 24,
  parameter int IPI_SRC = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      offer_vld,
  input  logic [SRC_W-1:0]          offer_src,
  input  logic [PRIO_W-1:0]         offer_prio,
  input  logic [2:0]                op_code,
  input  logic [PRIO_W+SRC_W-1:0]   op_data,
  output logic                      irq_out,
  output logic                      rsp_vld,
  output logic [PRIO_W+SRC_W-1:0]   rsp_word,
  output logic [PRIO_W-1:0]         rsp_ipi,
  output logic                      rej_vld,
  output logic [SRC_W-1:0]          rej_src,
  output logic                      resend_req,
  output logic                      eoi_vld,
  output logic [SRC_W-1:0]          eoi_src
);
  localparam int WORD_W = PRIO_W + SRC_W;
  localparam logic [SRC_W-1:0]  IPI_ID   = SRC_W'(IPI_SRC);
  localparam logic [PRIO_W-1:0] PRIO_OFF = {PRIO_W{1'b1}};

  ipu_op_e op;
  assign op = ipu_op_e'(op_code);

  // architectural state
  logic [PRIO_W-1:0] cur_q, held_q, sw_q;
  logic [SRC_W-1:0]  src_q;
  logic              line_q;
  // next-state
  logic [PRIO_W-1:0] cur_d, held_d, sw_d;
  logic [SRC_W-1:0]  src_d;
  logic              line_d;
  // registered outputs, next values
  logic              rsp_vld_d, rej_vld_d, resend_d, eoi_vld_d;
  logic [WORD_W-1:0] rsp_word_d;
  logic [PRIO_W-1:0] rsp_ipi_d;
  logic [SRC_W-1:0]  rej_src_d, eoi_src_d;

  logic              busy;
  logic [PRIO_W-1:0] arg_prio, arg_top;
  logic [PRIO_W-1:0] sw_cand, sw_ceiling;
  logic              sw_win, offer_win, offer_live;

  assign busy     = src_q != '0;
  assign arg_prio = op_data[PRIO_W-1:0];
  assign arg_top  = op_data[WORD_W-1 -: PRIO_W];
  assign offer_live = offer_vld && (op == OP_NONE)
                      && (offer_src != '0) && (offer_src != IPI_ID);

  // software interrupt check inputs: the candidate and the ceiling it
  // must beat depend on which operation invokes the check
  always_comb begin
    sw_cand    = sw_q;
    sw_ceiling = cur_q;
    case (op)
      OP_SET_SW:  sw_cand    = arg_prio;
      OP_SET_CUR: sw_ceiling = arg_prio;
      OP_DONE:    sw_ceiling = arg_top;
      default: ;
    endcase
  end

  ipu_prio_gate #(.PRIO_W(PRIO_W)) u_sw_gate (
    .cand_prio(sw_cand), .ceiling(sw_ceiling), .busy(busy),
    .held_prio(held_q), .win(sw_win)
  );

  ipu_prio_gate #(.PRIO_W(PRIO_W)) u_offer_gate (
    .cand_prio(offer_prio), .ceiling(cur_q), .busy(busy),
    .held_prio(held_q), .win(offer_win)
  );

  always_comb begin
    cur_d      = cur_q;
    held_d     = held_q;
    sw_d       = sw_q;
    src_d      = src_q;
    line_d     = line_q;
    rsp_vld_d  = 1'b0;
    rsp_word_d = rsp_word;
    rsp_ipi_d  = rsp_ipi;
    rej_vld_d  = 1'b0;
    rej_src_d  = '0;
    resend_d   = 1'b0;
    eoi_vld_d  = 1'b0;
    eoi_src_d  = '0;
    case (op)
      OP_SET_CUR: begin
        cur_d = arg_prio;
        if (arg_prio < cur_q) begin
          if (busy && (arg_prio <= held_q)) begin
            src_d  = '0;
            held_d = PRIO_OFF;
            line_d = 1'b0;
            if (src_q != IPI_ID) begin
              rej_vld_d = 1'b1;
              rej_src_d = src_q;
            end
          end
        end else if (!busy) begin
          resend_d = 1'b1;
          if (sw_win) begin
            src_d  = IPI_ID;
            held_d = sw_q;
            line_d = 1'b1;
          end
        end
      end
      OP_SET_SW: begin
        sw_d = arg_prio;
        if (sw_win) begin
          if (busy && (src_q != IPI_ID)) begin
            rej_vld_d = 1'b1;
            rej_src_d = src_q;
          end
          src_d  = IPI_ID;
          held_d = arg_prio;
          line_d = 1'b1;
        end
      end
      OP_ACCEPT: begin
        rsp_vld_d  = 1'b1;
        rsp_word_d = {cur_q, src_q};
        rsp_ipi_d  = sw_q;
        cur_d      = held_q;
        src_d      = '0;
        held_d     = PRIO_OFF;
        line_d     = 1'b0;
      end
      OP_DONE: begin
        cur_d     = arg_top;
        eoi_vld_d = 1'b1;
        eoi_src_d = op_data[SRC_W-1:0];
        if (!busy) begin
          resend_d = 1'b1;
          if (sw_win) begin
            src_d  = IPI_ID;
            held_d = sw_q;
            line_d = 1'b1;
          end
        end
      end
      OP_PEEK: begin
        rsp_vld_d  = 1'b1;
        rsp_word_d = {cur_q, src_q};
        rsp_ipi_d  = sw_q;
      end
      default: begin
        if (offer_live) begin
          if (offer_win) begin
            if (busy && (src_q != IPI_ID)) begin
              rej_vld_d = 1'b1;
              rej_src_d = src_q;
            end
            src_d  = offer_src;
            held_d = offer_prio;
            line_d = 1'b1;
          end else begin
            rej_vld_d = 1'b1;
            rej_src_d = offer_src;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q      <= '0;
      src_q      <= '0;
      held_q     <= PRIO_OFF;
      sw_q       <= PRIO_OFF;
      line_q     <= 1'b0;
      rsp_vld    <= 1'b0;
      rsp_word   <= '0;
      rsp_ipi    <= '0;
      rej_vld    <= 1'b0;
      rej_src    <= '0;
      resend_req <= 1'b0;
      eoi_vld    <= 1'b0;
      eoi_src    <= '0;
    end else begin
      cur_q      <= cur_d;
      src_q      <= src_d;
      held_q     <= held_d;
      sw_q       <= sw_d;
      line_q     <= line_d;
      rsp_vld    <= rsp_vld_d;
      rsp_word   <= rsp_word_d;
      rsp_ipi    <= rsp_ipi_d;
      rej_vld    <= rej_vld_d;
      rej_src    <= rej_src_d;
      resend_req <= resend_d;
      eoi_vld    <= eoi_vld_d;
      eoi_src    <= eoi_src_d;
    end
  end

  assign irq_out = line_q;

  // R1: state right after a reset cycle
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cur_q == '0 && src_q == '0 && held_q == PRIO_OFF
                    && sw_q == PRIO_OFF && !irq_out));

  // R11: line follows the source field
  assert_line_tracks_src_R11: assert property (@(posedge clk) disable iff (rst)
    irq_out == (src_q != '0));

  // R3: reserved numbers never go back to the source unit
  assert_no_reserved_reject_R3: assert property (@(posedge clk) disable iff (rst)
    rej_vld |-> (rej_src != IPI_ID && rej_src != '0));

  // R4: idle slot always carries the off priority
  assert_idle_held_off_R4: assert property (@(posedge clk) disable iff (rst)
    (src_q == '0) |-> (held_q == PRIO_OFF));

  // R8: EOI pulse echoes the end-of-service argument
  assert_eoi_echo_R8: assert property (@(posedge clk) disable iff (rst)
    eoi_vld |-> ($past(op_code) == OP_DONE
                 && eoi_src == $past(op_data[SRC_W-1:0])));

  // R9: poll leaves state untouched
  assert_poll_silent_R9: assert property (@(posedge clk) disable iff (rst)
    (op_code == OP_PEEK) |=> ($stable(cur_q) && $stable(src_q)
                              && $stable(held_q) && $stable(sw_q)));
endmodule

// File: tb/intr_present_unit_tb_top.sv
module intr_present_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 8;
  localparam int SW = 24;
  localparam int WW = 32;
  localparam logic [SW-1:0] IPI = 24'd2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic offer_vld = 1'b0;
  logic [SW-1:0] offer_src = '0;
  logic [PW-1:0] offer_prio = '0;
  logic [2:0] op_code = 3'd0;
  logic [WW-1:0] op_data = '0;
  logic irq_out, rsp_vld, rej_vld, resend_req, eoi_vld;
  logic [WW-1:0] rsp_word;
  logic [PW-1:0] rsp_ipi;
  logic [SW-1:0] rej_src, eoi_src;

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_present_unit dut_i (
    .clk(clk), .rst(rst), .offer_vld(offer_vld), .offer_src(offer_src),
    .offer_prio(offer_prio), .op_code(op_code), .op_data(op_data),
    .irq_out(irq_out), .rsp_vld(rsp_vld), .rsp_word(rsp_word),
    .rsp_ipi(rsp_ipi), .rej_vld(rej_vld), .rej_src(rej_src),
    .resend_req(resend_req), .eoi_vld(eoi_vld), .eoi_src(eoi_src)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // reference model state
  logic [PW-1:0] m_cur, m_held, m_sw;
  logic [SW-1:0] m_src;
  // expectations for the next sample
  logic e_rej, e_resend, e_eoi, e_rsp;
  logic [SW-1:0] e_rej_src, e_eoi_src;
  logic [WW-1:0] e_word;
  logic [PW-1:0] e_ipi;
  string e_tag;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic m_reset();
    m_cur = '0; m_src = '0; m_held = 8'hFF; m_sw = 8'hFF;
  endtask

  task automatic m_reject(input logic [SW-1:0] s);
    if (s != IPI) begin e_rej = 1'b1; e_rej_src = s; end
  endtask

  task automatic m_sw_check();
    if (m_src != 0 && m_held <= m_sw) return;
    if (m_src != 0) m_reject(m_src);
    m_src = IPI; m_held = m_sw;
  endtask

  task automatic m_resend();
    if (m_sw < m_cur) m_sw_check();
    e_resend = 1'b1;
  endtask

  task automatic m_step(input logic [2:0] op, input logic [WW-1:0] d,
                        input logic ov, input logic [SW-1:0] s,
                        input logic [PW-1:0] p);
    e_rej = 0; e_rej_src = 0; e_resend = 0; e_eoi = 0; e_eoi_src = 0; e_rsp = 0;
    e_word = 0; e_ipi = 0;
    case (op)
      3'd1: begin
        if (d[7:0] < m_cur) begin
          e_tag = "R5";
          if (m_src != 0 && d[7:0] <= m_held) begin
            m_reject(m_src); m_src = 0; m_held = 8'hFF;
          end
          m_cur = d[7:0];
        end else begin
          e_tag = "R6";
          m_cur = d[7:0];
          if (m_src == 0) m_resend();
        end
      end
      3'd2: begin
        e_tag = "R7";
        m_sw = d[7:0];
        if (m_sw < m_cur) m_sw_check();
      end
      3'd3: begin
        e_tag = "R4";
        e_rsp = 1; e_word = {m_cur, m_src}; e_ipi = m_sw;
        m_cur = m_held; m_src = 0; m_held = 8'hFF;
      end
      3'd4: begin
        e_tag = "R8";
        m_cur = d[31:24]; e_eoi = 1; e_eoi_src = d[23:0];
        if (m_src == 0) m_resend();
      end
      3'd5: begin
        e_tag = "R9";
        e_rsp = 1; e_word = {m_cur, m_src}; e_ipi = m_sw;
      end
      3'd0: begin
        if (ov && s != 0 && s != IPI) begin
          if (p >= m_cur || (m_src != 0 && m_held <= p)) begin
            e_tag = "R2"; e_rej = 1; e_rej_src = s;
          end else begin
            e_tag = "R3";
            if (m_src != 0) m_reject(m_src);
            m_src = s; m_held = p;
          end
        end else if (ov) e_tag = "R10";
        else e_tag = "R11";
      end
      default: e_tag = ov ? "R10" : "R11";
    endcase
    if (op != 3'd0 && ov) e_tag = "R10";
  endtask

  task automatic step(input logic [2:0] op, input logic [WW-1:0] d,
                      input logic ov, input logic [SW-1:0] s,
                      input logic [PW-1:0] p);
    op_code = op; op_data = d; offer_vld = ov; offer_src = s; offer_prio = p;
    m_step(op, d, ov, s, p);
    @(negedge clk);
    chk(e_tag, "irq_out", 32'(irq_out), 32'(m_src != 0));
    chk(e_tag, "rej_vld", 32'(rej_vld), 32'(e_rej));
    if (e_rej) chk(e_tag, "rej_src", 32'(rej_src), 32'(e_rej_src));
    chk(e_tag, "resend_req", 32'(resend_req), 32'(e_resend));
    chk(e_tag, "eoi_vld", 32'(eoi_vld), 32'(e_eoi));
    if (e_eoi) chk(e_tag, "eoi_src", 32'(eoi_src), 32'(e_eoi_src));
    chk(e_tag, "rsp_vld", 32'(rsp_vld), 32'(e_rsp));
    if (e_rsp) begin
      chk(e_tag, "rsp_word", rsp_word, e_word);
      chk(e_tag, "rsp_ipi", 32'(rsp_ipi), 32'(e_ipi));
    end
  endtask

  function automatic logic [PW-1:0] pick_prio();
    if ($urandom_range(0, 9) == 0) return 8'hFF;
    return PW'($urandom_range(0, 12));
  endfunction

  task automatic do_reset();
    rst = 1'b1; op_code = 0; offer_vld = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_reset();
    // R1: reset values observed at the ports
    chk("R1", "irq_out", 32'(irq_out), 32'd0);
    chk("R1", "rej_vld", 32'(rej_vld), 32'd0);
    step(3'd5, 0, 0, 0, 0);
    chk("R1", "peek word", rsp_word, 32'd0);
    chk("R1", "peek sw prio", 32'(rsp_ipi), 32'hFF);
  endtask

  initial begin
    void'($urandom(32'd7321));
    m_reset();
    do_reset();
    // directed corner cases
    step(0, 0, 1, 24'd20, 8'd5);          // R2: current priority 0 refuses all
    step(1, 32'hFF, 0, 0, 0);             // R6: loosen, idle -> resend
    step(0, 0, 1, 24'd20, 8'd5);          // R3: taken
    step(0, 0, 1, 24'd21, 8'd5);          // R2: tie with pending refused
    step(0, 0, 1, 24'd22, 8'd3);          // R3: bumps 20
    step(5, 0, 1, 24'd23, 8'd0);          // R10: offer on op cycle ignored
    step(0, 0, 1, 24'd2, 8'd0);           // R10: reserved number ignored
    step(2, 32'd1, 0, 0, 0);              // R7: software interrupt bumps 22
    step(3, 0, 0, 0, 0);                  // R4: accept the software interrupt
    chk("R4", "accept word", rsp_word, 32'hFF000002);
    step(4, 32'hFF000002, 0, 0, 0);       // R8: done, resend, sw re-presented
    step(1, 32'd0, 0, 0, 0);              // R5: drop pending sw without reject
    step(6, 0, 0, 0, 0);                  // R11: unused code
    step(2, 32'hFF, 0, 0, 0);
    step(1, 32'h10, 0, 0, 0);
    step(0, 0, 1, 24'd30, 8'd4);
    step(1, 32'd4, 0, 0, 0);              // R5: drop with reject of 30
    // constrained random
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [2:0] op;
      logic [WW-1:0] d;
      logic ov;
      logic [SW-1:0] s;
      r = $urandom_range(0, 99);
      if (r < 45) op = 3'd0;
      else if (r < 57) op = 3'd1;
      else if (r < 67) op = 3'd2;
      else if (r < 79) op = 3'd3;
      else if (r < 90) op = 3'd4;
      else if (r < 97) op = 3'd5;
      else op = 3'd7;
      d = {pick_prio(), SW'($urandom_range(16, 40))};
      if (op == 3'd1 || op == 3'd2) d = WW'(pick_prio());
      ov = (op == 3'd0) ? ($urandom_range(0, 9) != 0) : ($urandom_range(0, 9) == 0);
      s = ($urandom_range(0, 19) == 0) ? SW'($urandom_range(0, 2))
                                       : SW'($urandom_range(16, 40));
      step(op, d, ov, s, pick_prio());
      if (i == 2000) do_reset();
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule